// File: doc/BRIEF.md
# Single-Bank DRAM Command Spacing Monitor

This block watches the stream of commands addressed to one bank of a four-bank synchronous DRAM. It checks that each command comes late enough after the commands before it, and that the bank is in a state that can take the command. It tracks three bank states: idle, open (a row is active) and background refresh. It keeps two saturating cycle counters. One counts the cycles since the last accepted command. The other counts the cycles since the last row activation. The minimum gaps come from configuration inputs: mode-register delay, activate-to-access, activate-to-precharge, precharge recovery, write recovery, auto-precharge write recovery and refresh cycle time. Burst length is also an input, and half the burst length is derived from it.

Any command that breaks a rule produces a one-cycle pulse with a code that names the rule. The pulse is registered, so it appears in the cycle after the command. A sticky error flag stays set until reset.

A command that is wrong for the bank's current state is rejected. It does not change the tracked state or the timers. A command that is only too early is still taken as executed, so the following commands are timed from it.

Top module: `sdc_bank_timing_check`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `viol_pulse`, `viol_code` and `err_sticky` are 0. After reset the bank is idle and no spacing constraint is pending.
- R2: Each command with `cmd_valid` high at a rising edge is judged at that edge. The verdict is on `viol_pulse`/`viol_code` for exactly the following cycle. With no command, `viol_pulse` is 0 and `viol_code` is 0.
- R3: `err_sticky` goes to 1 in the same cycle as the first `viol_pulse` and stays 1 until reset.
- R4: Command encoding on `cmd_code`: 0 mode-register set, 1 activate, 2 masked activate, 3 read, 4 read with auto-precharge, 5 write, 6 write with auto-precharge, 7 precharge, 8 precharge-all, 9 masked precharge, 10 refresh, 11 self-refresh exit, 12 background-refresh start, 13 background-refresh exit. Codes 14 and 15 are reserved and give violation code 10.
- R5: A command the bank state cannot take gives code 1 and is ignored. The cases are: any read or write (codes 3 to 6) to an idle bank; activate, masked activate, mode set, refresh, self-refresh exit or background-refresh start to an open bank; and anything other than code 13 during background refresh.
- R6: Background-refresh exit (code 13) while no background refresh is running gives code 2 and is ignored.
- R7: After a mode-register set, any command fewer than `cfg_t_mrd` cycles later gives code 3.
- R8: After a refresh, self-refresh exit, background-refresh start or background-refresh exit, any command fewer than `cfg_t_refc` cycles later gives code 4.
- R9: A read or write (codes 3 to 6) fewer than `cfg_t_rcd` cycles after the last activate gives code 5.
- R10: A precharge of any kind (codes 7 to 9) to an open bank fewer than `cfg_t_ras` cycles after the activate gives code 6. A precharge to an idle bank is legal.
- R11: Let A be the spacing from the last activate. Half the burst length is 1, 2 or 4 for `cfg_burst_sel` 0, 1 or 2/3. Code 7 is given when A is not greater than `cfg_t_ras` minus half the burst length for a read with auto-precharge. It is also given when A is not greater than `cfg_t_ras` minus (1 + half burst + `cfg_t_wr`) for a write with auto-precharge.
- R12: An activate of either kind fewer than `cfg_t_rp` cycles after a precharge of any kind gives code 8.
- R13: An activate fewer than (half burst + `cfg_t_rp`) cycles after a read with auto-precharge gives code 9. So does an activate fewer than (half burst + 1 + `cfg_t_dal`) cycles after a write with auto-precharge.
- R14: The state checks (R4 to R6) take priority over the spacing checks. Among the spacing checks, R7 and R8 come before the command-specific rules, and R9 comes before R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command to this bank is present this cycle |
| cmd_code | input | 4 | Encoded command (R4) |
| cfg_burst_sel | input | 2 | Burst length select: 0=2, 1=4, 2 or 3=8 |
| cfg_t_mrd | input | T_W | Mode-set to next command, cycles |
| cfg_t_rcd | input | T_W | Activate to read/write, cycles |
| cfg_t_ras | input | T_W | Activate to precharge, cycles |
| cfg_t_rp | input | T_W | Precharge to activate, cycles |
| cfg_t_wr | input | T_W | Write recovery, cycles |
| cfg_t_dal | input | T_W | Write-with-auto-precharge recovery, cycles |
| cfg_t_refc | input | T_W | Refresh cycle time, cycles |
| viol_pulse | output | 1 | One-cycle violation strobe |
| viol_code | output | 4 | Rule broken (0 when none) |
| err_sticky | output | 1 | Set by any violation, cleared by reset |

## Verification
Directed sequences place commands exactly one cycle before and exactly at each boundary: activate to precharge, activate to auto-precharge accesses for each burst setting, and recovery after each kind of precharge. This separates off-by-one errors in each comparison. Random streams are biased towards commands the current state can take, with gaps of one to ten cycles. They are run under three configurations whose gaps and burst lengths all differ, so a rule tied to the wrong configuration input gives a wrong code. About a quarter of the random commands are drawn without regard to state. These exercise the rejection path and show that rejected commands leave the timers and the bank state untouched.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam logic [3:0] CMD_MRS   = 4'd0;
    localparam logic [3:0] CMD_ACT   = 4'd1;
    localparam logic [3:0] CMD_MACT  = 4'd2;
    localparam logic [3:0] CMD_RD    = 4'd3;
    localparam logic [3:0] CMD_RDA   = 4'd4;
    localparam logic [3:0] CMD_WR    = 4'd5;
    localparam logic [3:0] CMD_WRA   = 4'd6;
    localparam logic [3:0] CMD_PRE   = 4'd7;
    localparam logic [3:0] CMD_PALL  = 4'd8;
    localparam logic [3:0] CMD_MPRE  = 4'd9;
    localparam logic [3:0] CMD_REF   = 4'd10;
    localparam logic [3:0] CMD_SELFX = 4'd11;
    localparam logic [3:0] CMD_BREF  = 4'd12;
    localparam logic [3:0] CMD_BREFX = 4'd13;

    localparam logic [3:0] V_NONE     = 4'd0;
    localparam logic [3:0] V_STATE    = 4'd1;
    localparam logic [3:0] V_BREFX    = 4'd2;
    localparam logic [3:0] V_MRD      = 4'd3;
    localparam logic [3:0] V_REFC     = 4'd4;
    localparam logic [3:0] V_RCD      = 4'd5;
    localparam logic [3:0] V_RAS      = 4'd6;
    localparam logic [3:0] V_RAS_AUTO = 4'd7;
    localparam logic [3:0] V_RP       = 4'd8;
    localparam logic [3:0] V_AUTO_PRE = 4'd9;
    localparam logic [3:0] V_RSVD     = 4'd10;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_BGREF = 2'd2
    } bank_st_e;

    typedef enum logic [2:0] {
        LK_NONE  = 3'd0,
        LK_MRS   = 3'd1,
        LK_REF   = 3'd2,
        LK_PRE   = 3'd3,
        LK_RDA   = 3'd4,
        LK_WRA   = 3'd5,
        LK_OTHER = 3'd6
    } last_kind_e;

    typedef struct packed {
        bank_st_e   bank;
        last_kind_e last;
        logic       viol;
        logic [3:0] code;
        logic       err;
    } mon_state_t;

endpackage

// File: rtl/sdc_gap_timer.sv
module sdc_gap_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] gap_q
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] gap_d;

    // A restart means the next command is one cycle later; saturate otherwise.
    always_comb begin
        gap_d = gap_q;
        if (restart) begin
            gap_d = CNT_W'(1);
        end else if (gap_q != SAT) begin
            gap_d = gap_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= SAT;
        end else begin
            gap_q <= gap_d;
        end
    end
endmodule

// File: rtl/sdc_cmd_rules.sv
module sdc_cmd_rules
    import sdc_pkg::*;
#(
    parameter int T_W   = 8,
    parameter int CNT_W = 10
) (
    input  logic [3:0]       cmd_code,
    input  bank_st_e         bank,
    input  last_kind_e       last,
    input  logic [CNT_W-1:0] gap,
    input  logic [CNT_W-1:0] act_gap,
    input  logic [1:0]       cfg_burst_sel,
    input  logic [T_W-1:0]   cfg_t_mrd,
    input  logic [T_W-1:0]   cfg_t_rcd,
    input  logic [T_W-1:0]   cfg_t_ras,
    input  logic [T_W-1:0]   cfg_t_rp,
    input  logic [T_W-1:0]   cfg_t_wr,
    input  logic [T_W-1:0]   cfg_t_dal,
    input  logic [T_W-1:0]   cfg_t_refc,
    output logic [3:0]       code,
    output logic             accept
);
    localparam int W = ((CNT_W > T_W) ? CNT_W : T_W) + 3;

    logic [W-1:0] g, ag, hbl;
    logic [W-1:0] t_mrd, t_rcd, t_ras, t_rp, t_wr, t_dal, t_refc;
    logic [W-1:0] rda_reach, wra_reach, rda_rec, wra_rec;
    logic         is_act, is_access, is_pre, is_rsvd;

    assign g      = W'(gap);
    assign ag     = W'(act_gap);
    assign t_mrd  = W'(cfg_t_mrd);
    assign t_rcd  = W'(cfg_t_rcd);
    assign t_ras  = W'(cfg_t_ras);
    assign t_rp   = W'(cfg_t_rp);
    assign t_wr   = W'(cfg_t_wr);
    assign t_dal  = W'(cfg_t_dal);
    assign t_refc = W'(cfg_t_refc);

    always_comb begin
        case (cfg_burst_sel)
            2'd0:    hbl = W'(1);
            2'd1:    hbl = W'(2);
            default: hbl = W'(4);
        endcase
    end

    // Auto-precharge reach: the access end point must pass tRAS.
    assign rda_reach = ag + hbl;
    assign wra_reach = ag + hbl + W'(1) + t_wr;
    assign rda_rec   = hbl + t_rp;
    assign wra_rec   = hbl + W'(1) + t_dal;

    assign is_act    = (cmd_code == CMD_ACT) || (cmd_code == CMD_MACT);
    assign is_access = (cmd_code >= CMD_RD) && (cmd_code <= CMD_WRA);
    assign is_pre    = (cmd_code >= CMD_PRE) && (cmd_code <= CMD_MPRE);
    assign is_rsvd   = (cmd_code > CMD_BREFX);

    always_comb begin
        code = V_NONE;
        // State legality first.
        if (is_rsvd) begin
            code = V_RSVD;
        end else begin
            case (bank)
                BK_IDLE: begin
                    if (is_access)                   code = V_STATE;
                    else if (cmd_code == CMD_BREFX)  code = V_BREFX;
                end
                BK_OPEN: begin
                    if (is_act || cmd_code == CMD_MRS || cmd_code == CMD_REF ||
                        cmd_code == CMD_SELFX || cmd_code == CMD_BREF)
                        code = V_STATE;
                    else if (cmd_code == CMD_BREFX)  code = V_BREFX;
                end
                default: begin
                    if (cmd_code != CMD_BREFX)       code = V_STATE;
                end
            endcase
        end
        accept = (code == V_NONE);

        // Spacing rules for commands the state can take.
        if (accept) begin
            if (last == LK_MRS && g < t_mrd) begin
                code = V_MRD;
            end else if (last == LK_REF && g < t_refc) begin
                code = V_REFC;
            end else if (is_access) begin
                if (ag < t_rcd) begin
                    code = V_RCD;
                end else if (cmd_code == CMD_RDA && rda_reach <= t_ras) begin
                    code = V_RAS_AUTO;
                end else if (cmd_code == CMD_WRA && wra_reach <= t_ras) begin
                    code = V_RAS_AUTO;
                end
            end else if (is_pre) begin
                if (bank == BK_OPEN && ag < t_ras) code = V_RAS;
            end else if (is_act) begin
                if (last == LK_PRE && g < t_rp)            code = V_RP;
                else if (last == LK_RDA && g < rda_rec)    code = V_AUTO_PRE;
                else if (last == LK_WRA && g < wra_rec)    code = V_AUTO_PRE;
            end
        end
    end
endmodule

// File: rtl/sdc_bank_timing_check.sv
module sdc_bank_timing_check
    import sdc_pkg::*;
#(
    parameter int T_W   = 8,
    parameter int CNT_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_code,
    input  logic [1:0]     cfg_burst_sel,
    input  logic [T_W-1:0] cfg_t_mrd,
    input  logic [T_W-1:0] cfg_t_rcd,
    input  logic [T_W-1:0] cfg_t_ras,
    input  logic [T_W-1:0] cfg_t_rp,
    input  logic [T_W-1:0] cfg_t_wr,
    input  logic [T_W-1:0] cfg_t_dal,
    input  logic [T_W-1:0] cfg_t_refc,
    output logic           viol_pulse,
    output logic [3:0]     viol_code,
    output logic           err_sticky
);
    localparam int N_TMR = 2;
    localparam int TMR_CMD = 0;
    localparam int TMR_ACT = 1;

    mon_state_t s_d, s_q;

    logic [3:0]       rule_code;
    logic             rule_accept;
    logic             take;
    logic [N_TMR-1:0] restart;
    logic [CNT_W-1:0] gap_q [N_TMR];

    assign take             = cmd_valid && rule_accept;
    assign restart[TMR_CMD] = take;
    assign restart[TMR_ACT] = take && (cmd_code == CMD_ACT || cmd_code == CMD_MACT);

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        sdc_gap_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart[i]),
            .gap_q   (gap_q[i])
        );
    end

    sdc_cmd_rules #(.T_W(T_W), .CNT_W(CNT_W)) u_rules (
        .cmd_code      (cmd_code),
        .bank          (s_q.bank),
        .last          (s_q.last),
        .gap           (gap_q[TMR_CMD]),
        .act_gap       (gap_q[TMR_ACT]),
        .cfg_burst_sel (cfg_burst_sel),
        .cfg_t_mrd     (cfg_t_mrd),
        .cfg_t_rcd     (cfg_t_rcd),
        .cfg_t_ras     (cfg_t_ras),
        .cfg_t_rp      (cfg_t_rp),
        .cfg_t_wr      (cfg_t_wr),
        .cfg_t_dal     (cfg_t_dal),
        .cfg_t_refc    (cfg_t_refc),
        .code          (rule_code),
        .accept        (rule_accept)
    );

    always_comb begin
        s_d      = s_q;
        s_d.viol = 1'b0;
        s_d.code = V_NONE;
        if (cmd_valid) begin
            s_d.viol = (rule_code != V_NONE);
            s_d.code = rule_code;
            s_d.err  = s_q.err || (rule_code != V_NONE);
            if (rule_accept) begin
                case (cmd_code)
                    CMD_ACT, CMD_MACT: begin
                        s_d.bank = BK_OPEN;
                        s_d.last = LK_OTHER;
                    end
                    CMD_RDA: begin
                        s_d.bank = BK_IDLE;
                        s_d.last = LK_RDA;
                    end
                    CMD_WRA: begin
                        s_d.bank = BK_IDLE;
                        s_d.last = LK_WRA;
                    end
                    CMD_PRE, CMD_PALL, CMD_MPRE: begin
                        s_d.bank = BK_IDLE;
                        s_d.last = LK_PRE;
                    end
                    CMD_MRS:   s_d.last = LK_MRS;
                    CMD_REF, CMD_SELFX: s_d.last = LK_REF;
                    CMD_BREF: begin
                        s_d.bank = BK_BGREF;
                        s_d.last = LK_REF;
                    end
                    CMD_BREFX: begin
                        s_d.bank = BK_IDLE;
                        s_d.last = LK_REF;
                    end
                    default:   s_d.last = LK_OTHER;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{bank: BK_IDLE, last: LK_NONE, viol: 1'b0, code: V_NONE, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign viol_pulse = s_q.viol;
    assign viol_code  = s_q.code;
    assign err_sticky = s_q.err;
endmodule

// File: rtl/sdc_bank_timing_sva.sv
module sdc_bank_timing_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       viol_pulse,
    input logic [3:0] viol_code,
    input logic       err_sticky
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!viol_pulse && !err_sticky && viol_code == 4'd0));

    assert_pulse_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> $past(cmd_valid));

    assert_code_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_pulse |-> (viol_code == 4'd0));

    assert_sticky_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    assert_sticky_with_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> err_sticky);

    assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_code <= 4'd10);
endmodule

bind sdc_bank_timing_check sdc_bank_timing_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .viol_pulse (viol_pulse),
    .viol_code  (viol_code),
    .err_sticky (err_sticky)
);

// File: tb/tb_sdc_bank_timing_check.sv
`timescale 1ns/1ps
module tb_sdc_bank_timing_check;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic [1:0] cfg_burst_sel = 2'd1;
    logic [7:0] cfg_t_mrd = 8'd2, cfg_t_rcd = 8'd3, cfg_t_ras = 8'd6, cfg_t_rp = 8'd3;
    logic [7:0] cfg_t_wr = 8'd2, cfg_t_dal = 8'd4, cfg_t_refc = 8'd5;
    logic       viol_pulse, err_sticky;
    logic [3:0] viol_code;

    int checks = 0, failures = 0, cyc = 0;
    int m_st, m_last, m_last_t, m_act_t;
    bit sticky_exp;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdc_bank_timing_check dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cfg_burst_sel(cfg_burst_sel), .cfg_t_mrd(cfg_t_mrd), .cfg_t_rcd(cfg_t_rcd),
        .cfg_t_ras(cfg_t_ras), .cfg_t_rp(cfg_t_rp), .cfg_t_wr(cfg_t_wr),
        .cfg_t_dal(cfg_t_dal), .cfg_t_refc(cfg_t_refc),
        .viol_pulse(viol_pulse), .viol_code(viol_code), .err_sticky(err_sticky)
    );

    function automatic int hbl();
        return (cfg_burst_sel == 2'd0) ? 1 : (cfg_burst_sel == 2'd1) ? 2 : 4;
    endfunction

    // Expected code from the requirements (R4..R14); states 0 idle, 1 open, 2 bg.
    function automatic int exp_code(int c, int t);
        int g  = t - m_last_t;
        int ag = t - m_act_t;
        int h  = hbl();
        if (c > 13) return 10;
        if (m_st == 0 && c inside {3, 4, 5, 6}) return 1;
        if (m_st == 1 && c inside {0, 1, 2, 10, 11, 12}) return 1;
        if (m_st == 2 && c != 13) return 1;
        if (m_st != 2 && c == 13) return 2;
        if (m_last == 1 && g < int'(cfg_t_mrd)) return 3;
        if (m_last == 2 && g < int'(cfg_t_refc)) return 4;
        if (c inside {3, 4, 5, 6}) begin
            if (ag < int'(cfg_t_rcd)) return 5;
            if (c == 4 && ag <= int'(cfg_t_ras) - h) return 7;
            if (c == 6 && ag <= int'(cfg_t_ras) - (1 + h + int'(cfg_t_wr))) return 7;
        end
        if (c inside {7, 8, 9} && m_st == 1 && ag < int'(cfg_t_ras)) return 6;
        if (c inside {1, 2}) begin
            if (m_last == 3 && g < int'(cfg_t_rp)) return 8;
            if (m_last == 4 && g < h + int'(cfg_t_rp)) return 9;
            if (m_last == 5 && g < h + 1 + int'(cfg_t_dal)) return 9;
        end
        return 0;
    endfunction

    function automatic string req_of(int code);
        case (code)
            0: return "R2"; 1: return "R5"; 2: return "R6"; 3: return "R7";
            4: return "R8"; 5: return "R9"; 6: return "R10"; 7: return "R11";
            8: return "R12"; 9: return "R13"; default: return "R4";
        endcase
    endfunction

    task automatic model_upd(int c, int t, int code);
        if (code == 1 || code == 2 || code == 10) return;
        m_last_t = t;
        case (c)
            1, 2:       begin m_st = 1; m_last = 6; m_act_t = t; end
            4:          begin m_st = 0; m_last = 4; end
            6:          begin m_st = 0; m_last = 5; end
            7, 8, 9:    begin m_st = 0; m_last = 3; end
            0:          m_last = 1;
            10, 11:     m_last = 2;
            12:         begin m_st = 2; m_last = 2; end
            13:         begin m_st = 0; m_last = 2; end
            default:    m_last = 6;
        endcase
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(!viol_pulse && !err_sticky && viol_code == 0, "R1", "reset outputs",
              int'({viol_pulse, err_sticky, viol_code}), 0);
        rst_n = 1'b1;
        m_st = 0; m_last = 0; m_last_t = -100000; m_act_t = -100000; sticky_exp = 0;
        @(negedge clk);
        check(!viol_pulse && !err_sticky, "R1", "first cycle after reset",
              int'({viol_pulse, err_sticky}), 0);
    endtask

    task automatic send(int c);
        int t, e;
        cmd_valid = 1'b1; cmd_code = 4'(c);
        t = cyc;
        e = exp_code(c, t);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        sticky_exp = sticky_exp || (e != 0);
        check(viol_code == 4'(e) && viol_pulse == (e != 0), req_of(e), "viol code",
              int'(viol_code), e);
        check(err_sticky == sticky_exp, "R3", "sticky flag", int'(err_sticky), int'(sticky_exp));
        model_upd(c, t, e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) check(!viol_pulse && viol_code == 0, "R2", "pulse lasts one cycle",
                              int'(viol_code), 0);
        end
    endtask

    function automatic int pick_cmd();
        int r = int'($urandom % 100);
        if (r < 25) return int'($urandom % 16);
        case (m_st)
            0: begin
                int k = int'($urandom % 8);
                return (k < 3) ? 1 : (k == 3) ? 2 : (k == 4) ? 10 : (k == 5) ? 0 :
                       (k == 6) ? 12 : 7;
            end
            1: begin
                int k = int'($urandom % 7);
                return (k < 2) ? 3 + k : (k < 4) ? 3 + k : 7 + (k - 4);
            end
            default: return 13;
        endcase
    endfunction

    task automatic set_cfg(int sel);
        case (sel)
            0: begin cfg_burst_sel = 2'd1; cfg_t_mrd = 8'd2; cfg_t_rcd = 8'd3; cfg_t_ras = 8'd6;
                     cfg_t_rp = 8'd3; cfg_t_wr = 8'd2; cfg_t_dal = 8'd4; cfg_t_refc = 8'd5; end
            1: begin cfg_burst_sel = 2'd2; cfg_t_mrd = 8'd3; cfg_t_rcd = 8'd2; cfg_t_ras = 8'd9;
                     cfg_t_rp = 8'd2; cfg_t_wr = 8'd3; cfg_t_dal = 8'd5; cfg_t_refc = 8'd7; end
            default: begin cfg_burst_sel = 2'd0; cfg_t_mrd = 8'd1; cfg_t_rcd = 8'd4; cfg_t_ras = 8'd5;
                     cfg_t_rp = 8'd4; cfg_t_wr = 8'd1; cfg_t_dal = 8'd3; cfg_t_refc = 8'd3; end
        endcase
    endtask

    initial begin
        #(8ns * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        set_cfg(0);
        do_reset();
        // Directed corner cases, config 0 (half burst 2, tRAS 6).
        send(3);  idle(1);          // R5 read to idle bank
        send(13); idle(1);          // R6 exit with no background refresh
        send(14); idle(1);          // R4 reserved code
        send(1);  idle(3); send(7); // R10 precharge at spacing 4 (< 6)
        idle(1);  send(1);          // R12 activate 2 cycles after precharge
        idle(4);  send(9);          // R10 boundary, spacing 5 then check
        idle(2);  send(1);          // R12 at exactly tRP
        idle(1);  send(4);          // R11 read-auto at spacing 2 -> R9 first (R14)
        do_reset();
        send(1); idle(2); send(4);  // spacing 3: 3+2 <= 6 -> R11
        do_reset();
        send(1); idle(4); send(4);  // spacing 5: 5+2 > 6 legal
        idle(2); send(1);           // R13 spacing 3 < 2+3
        do_reset();
        send(1); idle(2); send(6);  // R11 write-auto, 3+1+2+2 > 6 legal
        idle(6); send(1);           // R13 spacing 7 == 2+1+4 legal
        do_reset();
        send(0); send(1);           // R7 spacing 1 < 2
        do_reset();
        send(12); idle(1); send(3); // R5 read during background refresh
        send(13); send(10);         // R8 refresh-cycle spacing after exit
        // Random phase under three configurations.
        for (int cfg = 0; cfg < 3; cfg++) begin
            set_cfg(cfg);
            do_reset();
            for (int n = 0; n < 700; n++) begin
                send(pick_cmd());
                idle(int'($urandom % 10));
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule